// File: doc/BRIEF.md
# NOR Flash Identification Sequencer

This block reads the manufacturer code out of a 16-bit parallel NOR flash without any software involvement. A single start pulse makes it drive a short command script onto a static-memory master port: two unlock writes, the identification-mode command, one read of the code, and finally the command that puts the flash back into normal array-read mode. The code read back appears on an output register. A one-cycle done pulse ends every run.

The flash can be a single x16 device on a 16-bit bus, or two x16 devices side by side on a 32-bit bus. A mode input selects which. In the single case, word offsets become byte addresses by one left shift. In the paired case they shift left by two, and each command byte is written to both 16-bit halves.

After reset the block holds off all bus traffic for a programmable number of clocks. This covers the flash's power-up and reset recovery. A start that arrives during this wait is remembered and carried out once the wait ends. Every access waits for its bus acknowledge. If an acknowledge does not arrive within a fixed limit, the run is abandoned and an error flag is raised.

Top module: `nor_id_seq`

## Requirements
- R1: After reset is released, `bus_req` stays low for exactly PWRUP_CYCLES clocks. A start pulse received during that time is held, and its sequence begins on the first cycle after the wait.
- R2: A sequence issues exactly five accesses, in this order: write 0xAA at word offset 0x555, write 0x55 at word offset 0x2AA, write 0x90 at word offset 0x555, read at offset 0, and write 0xF0 at offset 0. `bus_we`=1 marks a write.
- R3: With `pair_mode`=0, `bus_addr` is the word offset shifted left by one. `bus_wdata` carries the command in bits 7:0 and zero elsewhere.
- R4: With `pair_mode`=1, `bus_addr` is the word offset shifted left by two. The command appears in bits 7:0 and 23:16, and all other bits are zero (for example 0x00AA00AA). The mode is sampled on the cycle a sequence begins.
- R5: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` hold their values. After an acknowledged access, the next access is presented in the following cycle.
- R6: `id_value` takes `bus_rdata[15:0]` from the acknowledged read in both modes. It keeps that value until the next acknowledged read, including across a timed-out run.
- R7: `done` is high for exactly one cycle after the final write is acknowledged.
- R8: A request counts as timed out if `bus_ack` has not arrived by its ACK_LIMIT-th cycle; an acknowledge on that ACK_LIMIT-th cycle is still accepted. On a timeout, `bus_req` drops, `timeout_err` goes high, `done` pulses once, and no further access is issued.
- R9: `timeout_err` stays high until the next sequence begins. A start pulse that arrives while a sequence is running is ignored.
- R10: During and right after reset, `bus_req`, `done`, `timeout_err` and `id_value` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to run the identification sequence |
| pair_mode | input | 1 | 0: single x16 device, 1: interleaved pair on a 32-bit bus |
| bus_req | output | 1 | Access request to the static memory port |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W (24) | Byte address of the access |
| bus_wdata | output | DATA_W (32) | Write data |
| bus_rdata | input | DATA_W (32) | Read data, valid with `bus_ack` on a read |
| bus_ack | input | 1 | Access completed |
| id_value | output | ID_W (16) | Manufacturer code last read |
| done | output | 1 | One-cycle end-of-run pulse |
| timeout_err | output | 1 | Last run ended on an acknowledge timeout |

## Verification
The embedded properties check these rules on every cycle:
- no request is made before the power-up wait has finished;
- request fields stay frozen while an acknowledge is outstanding;
- `done` is a single-cycle pulse, and a rising timeout flag coincides with it;
- in paired mode, write data has two identical halves.

Only the bench scenarios can show the rest:
- the order and exact content of the five accesses in each mode;
- where the acknowledge limit falls, with a latency equal to the limit passing and one more timing out;
- that an early start is honoured and a start during a run is ignored;
- that a read code survives a timed-out run.

// File: rtl/nor_id_pkg.sv
// Package nor_id_pkg
// Shared types and the fixed command script of the identification sequencer.
// Assumes word offsets fit in 12 bits and command bytes in 8 bits.
package nor_id_pkg;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic        we;
        logic [11:0] offset;
        logic [7:0]  cmd;
    } step_t;

    localparam int NUM_STEPS = 5;
    localparam int STEP_W    = 3;
    localparam logic [STEP_W-1:0] READ_STEP = 3'd3;
    localparam logic [STEP_W-1:0] LAST_STEP = 3'(NUM_STEPS - 1);

    // Returns the access of script position idx; the order is the protocol.
    function automatic step_t step_info(input logic [STEP_W-1:0] idx);
        step_t s;
        case (idx)
            3'd0:    s = '{we: 1'b1, offset: 12'h555, cmd: 8'hAA};
            3'd1:    s = '{we: 1'b1, offset: 12'h2AA, cmd: 8'h55};
            3'd2:    s = '{we: 1'b1, offset: 12'h555, cmd: 8'h90};
            3'd3:    s = '{we: 1'b0, offset: 12'h000, cmd: 8'h00};
            default: s = '{we: 1'b1, offset: 12'h000, cmd: 8'hF0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nor_id_cmd_gen.sv
// Module nor_id_cmd_gen
// Turns a script position and the bus arrangement into the write enable,
// byte address and data word of that access. Purely combinational.
// Assumes DATA_W is a multiple of 16 and at least 32, ADDR_W >= 14.
module nor_id_cmd_gen
    import nor_id_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic [STEP_W-1:0] step,
    input  logic              pair,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);
    localparam int LANES = DATA_W / 16;

    step_t              cur;
    logic [ADDR_W-1:0]  off_ext;

    // Look up the step and scale its word offset by the bus arrangement.
    always_comb begin
        cur     = step_info(step);
        off_ext = ADDR_W'(cur.offset);
        we      = cur.we;
        addr    = pair ? (off_ext << 2) : (off_ext << 1);
    end

    // Each 16-bit lane carries the command if its device is present.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_first
            assign wdata[g*16 +: 16] = {8'h00, cur.cmd};
        end else if (g == 1) begin : g_second
            assign wdata[g*16 +: 16] = pair ? {8'h00, cur.cmd} : 16'h0000;
        end else begin : g_rest
            assign wdata[g*16 +: 16] = 16'h0000;
        end
    end

endmodule

// File: rtl/nor_id_pwrup_timer.sv
// Module nor_id_pwrup_timer
// Counts clocks after reset and raises ready once PWRUP_CYCLES have passed.
// Assumes PWRUP_CYCLES >= 1; the count saturates.
module nor_id_pwrup_timer #(
    parameter int PWRUP_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    localparam int CNT_W = $clog2(PWRUP_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(PWRUP_CYCLES);

    logic [CNT_W-1:0] cnt;

    // Advance the recovery count until it reaches the programmed wait.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (cnt != CNT_END) cnt <= cnt + 1'b1;
    end

    assign ready = (cnt == CNT_END);

    a_r1_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_END);

    a_r1_ready_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

endmodule

// File: rtl/nor_id_ack_watch.sv
// Module nor_id_ack_watch
// Counts the cycles an access has been outstanding and flags expiry on its
// ACK_LIMIT-th cycle without an acknowledge. Restarts after every ack.
// Assumes ACK_LIMIT >= 2.
module nor_id_ack_watch #(
    parameter int ACK_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic ack,
    output logic expire
);
    localparam int CNT_W = $clog2(ACK_LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    // Count waiting cycles of the current access; clear on ack or idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || ack) cnt <= '0;
        else if (cnt != CNT_LAST)     cnt <= cnt + 1'b1;
    end

    assign expire = active && !ack && (cnt == CNT_LAST);

    a_r8_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST);

endmodule

// File: rtl/nor_id_seq.sv
// Module nor_id_seq
// Identification sequencer for a parallel NOR flash. On start, after the
// power-up wait, it runs unlock, unlock, identify, read code, return-to-read
// on a request/acknowledge memory port, stores the code and pulses done.
// Assumes bus_ack is a one-cycle response to a held bus_req.
module nor_id_seq
    import nor_id_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int DATA_W       = 32,
    parameter int ID_W         = 16,
    parameter int PWRUP_CYCLES = 64,
    parameter int ACK_LIMIT    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              pair_mode,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    output logic [ID_W-1:0]   id_value,
    output logic              done,
    output logic              timeout_err
);
    seq_state_t        state;
    logic [STEP_W-1:0] step;
    logic              mode_q;
    logic              start_pend;
    logic [ID_W-1:0]   id_q;
    logic              done_q;
    logic              tmo_q;
    logic              pwr_ready;
    logic              ack_expire;
    logic              unused_rdata;

    assign unused_rdata = ^bus_rdata[DATA_W-1:ID_W];

    nor_id_pwrup_timer #(.PWRUP_CYCLES(PWRUP_CYCLES)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (pwr_ready)
    );

    nor_id_ack_watch #(.ACK_LIMIT(ACK_LIMIT)) i_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (bus_req),
        .ack    (bus_ack),
        .expire (ack_expire)
    );

    nor_id_cmd_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_cmd (
        .step  (step),
        .pair  (mode_q),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata)
    );

    // Sequencer: start capture, step advance, code capture, end of run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            step       <= '0;
            mode_q     <= 1'b0;
            start_pend <= 1'b0;
            id_q       <= '0;
            done_q     <= 1'b0;
            tmo_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (pwr_ready && (start || start_pend)) begin
                        state      <= ST_ACCESS;
                        step       <= '0;
                        mode_q     <= pair_mode;
                        tmo_q      <= 1'b0;
                        start_pend <= 1'b0;
                    end else if (start) begin
                        start_pend <= 1'b1;
                    end
                end
                default: begin
                    if (bus_ack) begin
                        if (step == READ_STEP) id_q <= bus_rdata[ID_W-1:0];
                        if (step == LAST_STEP) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            step <= step + 1'b1;
                        end
                    end else if (ack_expire) begin
                        state  <= ST_IDLE;
                        tmo_q  <= 1'b1;
                        done_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign bus_req     = (state == ST_ACCESS);
    assign id_value    = id_q;
    assign done        = done_q;
    assign timeout_err = tmo_q;

    // R1: no request while the flash is still recovering.
    a_r1_no_early_req: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ready |-> !bus_req);

    // R5: an unacknowledged, unexpired request keeps its fields.
    a_r5_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !ack_expire) |=>
            (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R4: paired arrangement writes identical halves.
    a_r4_pair_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && mode_q) |-> (bus_wdata[31:16] == bus_wdata[15:0]));

    // R7: done lasts one cycle.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the error appears together with the end-of-run pulse and no request.
    a_r8_tmo_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (done && !bus_req));

endmodule

// File: tb/test_nor_id_seq.sv
// Bench for nor_id_seq: a responding memory model, a vector table walked by
// one loop, then directed tests for power-up, busy start and limits.
module test_nor_id_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PWRUP      = 20;
    localparam int LIMIT      = 8;
    localparam int AW         = 24;
    localparam int DW         = 32;

    typedef struct packed {
        logic        pair;
        logic [7:0]  lat;
        logic [31:0] rdata;
        logic        tmo;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd1, 32'h0000_0001, 1'b0},
        '{1'b1, 8'd1, 32'h0001_0001, 1'b0},
        '{1'b0, 8'd3, 32'hBEEF_0089, 1'b0},
        '{1'b1, 8'd8, 32'h1234_00C2, 1'b0},
        '{1'b0, 8'd9, 32'h0000_0077, 1'b1},
        '{1'b1, 8'd2, 32'h0000_0020, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          pair_mode = 1'b0;
    logic          bus_req, bus_we, done, timeout_err;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_ack = 1'b0;
    logic [15:0]   id_value;

    int checks = 0;
    int errors = 0;
    int model_lat = 1;
    logic [31:0] model_rdata = '0;
    int req_run = 0;
    int log_n = 0;
    int done_cnt = 0;
    logic          log_we   [16];
    logic [AW-1:0] log_addr [16];
    logic [DW-1:0] log_data [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_id_seq #(
        .ADDR_W(AW), .DATA_W(DW), .ID_W(16),
        .PWRUP_CYCLES(PWRUP), .ACK_LIMIT(LIMIT)
    ) i_nor_id_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .pair_mode(pair_mode),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .id_value(id_value), .done(done), .timeout_err(timeout_err)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Memory model: acknowledges on the model_lat-th cycle of a request.
    initial begin
        forever begin
            @(negedge clk);
            bus_ack = 1'b0;
            if (done) done_cnt++;
            if (bus_req) begin
                req_run++;
                if (req_run == model_lat) begin
                    bus_ack   = 1'b1;
                    bus_rdata = model_rdata;
                    req_run   = 0;
                    if (log_n < 16) begin
                        log_we[log_n]   = bus_we;
                        log_addr[log_n] = bus_addr;
                        log_data[log_n] = bus_wdata;
                    end
                    log_n++;
                end
            end else begin
                req_run = 0;
            end
        end
    end

    function automatic logic [AW-1:0] exp_addr(input logic pair, input logic [11:0] off);
        return pair ? (AW'(off) << 2) : (AW'(off) << 1);
    endfunction

    function automatic logic [DW-1:0] exp_data(input logic pair, input logic [7:0] c);
        return pair ? {8'h00, c, 8'h00, c} : {24'h0, c};
    endfunction

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000; i++) begin
            if (done) break;
            @(negedge clk);
        end
    endtask

    // R2, R3, R4: compare the logged accesses with the script.
    task automatic check_script(input logic pair);
        logic [11:0] offs [5];
        logic [7:0]  cmds [5];
        offs = '{12'h555, 12'h2AA, 12'h555, 12'h000, 12'h000};
        cmds = '{8'hAA, 8'h55, 8'h90, 8'h00, 8'hF0};
        check(log_n, 5, "R2 access count");
        for (int k = 0; k < 5; k++) begin
            check({31'h0, log_we[k]}, (k == 3) ? 32'h0 : 32'h1, "R2 access kind");
            check(32'(log_addr[k]), 32'(exp_addr(pair, offs[k])),
                  pair ? "R4 pair address" : "R3 single address");
            if (k != 3)
                check(log_data[k], exp_data(pair, cmds[k]),
                      pair ? "R4 pair data" : "R3 single data");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] exp_id;
        int low_cycles;
        int dc;
        // R10: reset state
        repeat (3) @(negedge clk);
        check({31'h0, bus_req}, 0, "R10 req in reset");
        check({31'h0, done}, 0, "R10 done in reset");
        check({31'h0, timeout_err}, 0, "R10 tmo in reset");
        check({16'h0, id_value}, 0, "R10 id in reset");
        // R1: start right after release, measure the hold-off
        model_lat = 1;
        model_rdata = 32'h0000_0001;
        log_n = 0;
        rst_n = 1'b1;
        start = 1'b1;
        low_cycles = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (bus_req) break;
            low_cycles++;
        end
        check(low_cycles, PWRUP, "R1 power-up hold-off");
        wait_done();
        check_script(1'b0);
        check({16'h0, id_value}, 32'h0001, "R1 pending start honoured");
        exp_id = id_value;

        // Vector table
        for (int v = 0; v < NV; v++) begin
            pair_mode   = VECS[v].pair;
            model_lat   = int'(VECS[v].lat);
            model_rdata = VECS[v].rdata;
            log_n = 0;
            dc = done_cnt;
            pulse_start();
            wait_done();
            check({31'h0, done}, 1, "R7 done raised");
            @(negedge clk);
            check({31'h0, done}, 0, "R7 done one cycle");
            check(done_cnt - dc, 1, "R7 single done per run");
            if (VECS[v].tmo) begin
                check({31'h0, timeout_err}, 1, "R8 timeout flagged");
                check(log_n, 0, "R8 no access acknowledged");
                check({31'h0, bus_req}, 0, "R8 request dropped");
                check({16'h0, id_value}, {16'h0, exp_id}, "R6 id kept over timeout");
            end else begin
                check({31'h0, timeout_err}, 0, "R9 timeout clear");
                check_script(VECS[v].pair);
                exp_id = VECS[v].rdata[15:0];
                check({16'h0, id_value}, {16'h0, exp_id}, "R6 id value");
            end
        end

        // R5: fields hold while ack is slow
        pair_mode = 1'b1;
        model_lat = 4;
        model_rdata = 32'h0000_0004;
        log_n = 0;
        pulse_start();
        begin
            logic [AW-1:0] a0;
            logic [DW-1:0] d0;
            @(negedge clk);
            a0 = bus_addr;
            d0 = bus_wdata;
            @(negedge clk);
            check(32'(bus_addr), 32'(a0), "R5 address held");
            check(bus_wdata, d0, "R5 data held");
        end
        // R9: start during a run is ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dc = done_cnt;
        wait_done();
        repeat (30) @(negedge clk);
        check(log_n, 5, "R9 busy start ignored");
        check({31'h0, bus_req}, 0, "R9 no second run");

        // R8: latency one past the limit mid-run then recovery
        model_lat = LIMIT + 1;
        log_n = 0;
        pulse_start();
        wait_done();
        @(negedge clk);
        check({31'h0, timeout_err}, 1, "R8 limit plus one times out");
        repeat (LIMIT + 4) @(negedge clk);
        check({31'h0, bus_req}, 0, "R8 stays idle after timeout");
        model_lat = 1;
        pulse_start();
        check({31'h0, timeout_err}, 0, "R9 cleared at new start");
        wait_done();
        check({16'h0, id_value}, 32'h0004, "R6 id after recovery");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule